// File: doc/BRIEF.md
# Decode-Stage Hazard and Redirect Control

This block is the decode-stage steering logic of a small five-stage pipelined processor with an 8-bit datapath and 32-bit instruction words. It looks at the instruction held in the fetch/decode pipeline register and at the load flag and destination field of the instruction one stage ahead. From these it decides whether the front of the pipeline must hold for one cycle, because a load result is needed too early. It also decides whether a branch is taken, and whether the fetch slot must be discarded.

Branches are resolved in decode by comparing the two register read values for equality. The block computes the branch and jump targets and selects the next fetch address. It also produces the 8-bit control word that goes into the decode/execute register, forcing it to zero when a bubble is needed. Every output is a combinational function of the inputs. The surrounding register file, ALU, memories and pipeline registers sit outside this block.

Top module: `id_steer`

## Requirements
- R1: `hold_req` is 1 exactly when `ex_load` is 1 and `ex_dst` equals the first source field (`id_instr[25:21]`) or the second source field (`id_instr[20:16]`); with `ex_load` at 0 it is 0 whatever the fields hold.
- R2: While `hold_req` is 1, `pc_load` and `ifid_load` are both 0; otherwise both are 1.
- R3: `br_take` is 1 exactly when `ctl_branch` is 1 and `opnd_a` equals `opnd_b` in all 8 bits.
- R4: `ifid_clear` is 1 exactly when `br_take` or `ctl_jump` is 1.
- R5: `ctl_word` is all zeros whenever `hold_req` or `br_take` is 1.
- R6: Otherwise `ctl_word` carries, from bit 7 down to bit 0: `ctl_dst_rd`, `ctl_aluop[1]`, `ctl_aluop[0]`, `ctl_imm_b`, `ctl_mem_rd`, `ctl_mem_wr`, `ctl_reg_wr`, `ctl_wb_mem`.
- R7: `br_dest` equals `(id_pc4 + 4 * id_instr[5:0]) mod 256`.
- R8: `jmp_dest` equals `4 * id_instr[5:0]`, that is, the six low instruction bits followed by two zero bits.
- R9: `fetch_next` is `jmp_dest` when `ctl_jump` is 1. Otherwise it is `br_dest` when `br_take` is 1, and `if_pc4` in all other cases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_instr | input | 32 | Instruction held in the fetch/decode register |
| id_pc4 | input | 8 | Incremented address that travelled with that instruction |
| if_pc4 | input | 8 | Incremented address of the current fetch |
| opnd_a | input | 8 | Register value read for the first source field |
| opnd_b | input | 8 | Register value read for the second source field |
| ctl_dst_rd | input | 1 | Decoder: write destination comes from the third register field |
| ctl_aluop | input | 2 | Decoder: ALU operation class |
| ctl_imm_b | input | 1 | Decoder: ALU second operand is the immediate |
| ctl_mem_rd | input | 1 | Decoder: data memory read |
| ctl_mem_wr | input | 1 | Decoder: data memory write |
| ctl_reg_wr | input | 1 | Decoder: register file write |
| ctl_wb_mem | input | 1 | Decoder: write-back value comes from memory |
| ctl_branch | input | 1 | Decoder: conditional branch on equality |
| ctl_jump | input | 1 | Decoder: unconditional jump |
| ex_load | input | 1 | Instruction in execute reads data memory |
| ex_dst | input | 5 | Second source field of the instruction in execute |
| pc_load | output | 1 | Program counter write enable |
| ifid_load | output | 1 | Fetch/decode register write enable |
| ifid_clear | output | 1 | Discard the fetch/decode register contents |
| hold_req | output | 1 | Load-use hold, selects the bubble |
| br_take | output | 1 | Branch resolved taken |
| br_dest | output | 8 | Branch target address |
| jmp_dest | output | 8 | Jump target address |
| fetch_next | output | 8 | Next program counter value |
| ctl_word | output | 8 | Control word toward the decode/execute register |

## Verification
The sweep varies the execute-stage destination so that it matches the first source field, the second, both or neither, with the load flag on and off. This separates a correct two-field compare from one that checks a single field or ignores the load flag. Operand pairs that are equal, unequal only in the top bit, and unequal in low bits, together with every combination of branch and jump bits, separate a full-width compare from a truncated one. They also show the priority of jump over branch in the next-address choice. Each control bit is driven alone, so a swapped bit position in the control word is caught, and vectors where hold and taken branch coincide confirm that the bubble is still forced.

// File: rtl/id_steer.sv
module id_steer #(
  parameter int ADDR_W  = 8,
  parameter int INSTR_W = 32,
  parameter int FIELD_W = 5,
  parameter int OFFS_W  = 6
) (
  input  logic [INSTR_W-1:0] id_instr,
  input  logic [ADDR_W-1:0]  id_pc4,
  input  logic [ADDR_W-1:0]  if_pc4,
  input  logic [ADDR_W-1:0]  opnd_a,
  input  logic [ADDR_W-1:0]  opnd_b,
  input  logic               ctl_dst_rd,
  input  logic [1:0]         ctl_aluop,
  input  logic               ctl_imm_b,
  input  logic               ctl_mem_rd,
  input  logic               ctl_mem_wr,
  input  logic               ctl_reg_wr,
  input  logic               ctl_wb_mem,
  input  logic               ctl_branch,
  input  logic               ctl_jump,
  input  logic               ex_load,
  input  logic [FIELD_W-1:0] ex_dst,
  output logic               pc_load,
  output logic               ifid_load,
  output logic               ifid_clear,
  output logic               hold_req,
  output logic               br_take,
  output logic [ADDR_W-1:0]  br_dest,
  output logic [ADDR_W-1:0]  jmp_dest,
  output logic [ADDR_W-1:0]  fetch_next,
  output logic [7:0]         ctl_word
);
  localparam int SRC1_LO = 21;
  localparam int SRC2_LO = 16;
  localparam int PAD_W   = ADDR_W - OFFS_W;

  logic [FIELD_W-1:0] src1, src2;
  logic [ADDR_W-1:0]  offs;
  logic [ADDR_W-1:0]  seq_or_br;
  logic [7:0]         raw_word;
  logic               kill_ctl;

  assign src1 = id_instr[SRC1_LO +: FIELD_W];
  assign src2 = id_instr[SRC2_LO +: FIELD_W];

  assign hold_req  = ex_load && ((ex_dst == src1) || (ex_dst == src2));
  assign pc_load   = !hold_req;
  assign ifid_load = !hold_req;

  assign br_take    = ctl_branch && (opnd_a == opnd_b);
  assign ifid_clear = br_take || ctl_jump;

  assign offs     = {id_instr[OFFS_W-1:0], {PAD_W{1'b0}}};
  assign br_dest  = id_pc4 + offs;
  assign jmp_dest = {id_instr[OFFS_W-1:0], {PAD_W{1'b0}}};

  assign seq_or_br  = br_take ? br_dest : if_pc4;
  assign fetch_next = ctl_jump ? jmp_dest : seq_or_br;

  assign raw_word = {ctl_dst_rd, ctl_aluop, ctl_imm_b,
                     ctl_mem_rd, ctl_mem_wr, ctl_reg_wr, ctl_wb_mem};
  assign kill_ctl = hold_req || br_take;
  assign ctl_word = kill_ctl ? 8'h00 : raw_word;

  always_comb begin
    if (hold_req) begin
      assert_hold_freezes_R2: assert (!pc_load && !ifid_load);
    end
    if (hold_req) begin
      assert_hold_needs_load_R1: assert (ex_load);
    end
    if (br_take) begin
      assert_taken_equal_R3: assert (opnd_a == opnd_b && ifid_clear);
    end
    if (ctl_jump) begin
      assert_jump_clears_R4: assert (ifid_clear);
    end
    if (hold_req || br_take) begin
      assert_bubble_zero_R5: assert (ctl_word == 8'h00);
    end
    if (ctl_jump) begin
      assert_jump_wins_R9: assert (fetch_next == jmp_dest);
    end
  end
endmodule

// File: tb/id_steer_tb.sv
module id_steer_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [31:0] id_instr;
  logic [7:0]  id_pc4, if_pc4, opnd_a, opnd_b;
  logic        ctl_dst_rd, ctl_imm_b, ctl_mem_rd, ctl_mem_wr, ctl_reg_wr, ctl_wb_mem;
  logic [1:0]  ctl_aluop;
  logic        ctl_branch, ctl_jump, ex_load;
  logic [4:0]  ex_dst;
  logic        pc_load, ifid_load, ifid_clear, hold_req, br_take;
  logic [7:0]  br_dest, jmp_dest, fetch_next, ctl_word;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  id_steer u_dut (
    .id_instr(id_instr), .id_pc4(id_pc4), .if_pc4(if_pc4),
    .opnd_a(opnd_a), .opnd_b(opnd_b),
    .ctl_dst_rd(ctl_dst_rd), .ctl_aluop(ctl_aluop), .ctl_imm_b(ctl_imm_b),
    .ctl_mem_rd(ctl_mem_rd), .ctl_mem_wr(ctl_mem_wr), .ctl_reg_wr(ctl_reg_wr),
    .ctl_wb_mem(ctl_wb_mem), .ctl_branch(ctl_branch), .ctl_jump(ctl_jump),
    .ex_load(ex_load), .ex_dst(ex_dst),
    .pc_load(pc_load), .ifid_load(ifid_load), .ifid_clear(ifid_clear),
    .hold_req(hold_req), .br_take(br_take), .br_dest(br_dest),
    .jmp_dest(jmp_dest), .fetch_next(fetch_next), .ctl_word(ctl_word)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    id_instr = '0; id_pc4 = '0; if_pc4 = '0; opnd_a = '0; opnd_b = 8'h01;
    {ctl_dst_rd, ctl_aluop, ctl_imm_b, ctl_mem_rd, ctl_mem_wr, ctl_reg_wr, ctl_wb_mem} = '0;
    ctl_branch = 0; ctl_jump = 0; ex_load = 0; ex_dst = 5'd3;
    @(negedge clk);
    chk("R2 idle pc_load", int'(pc_load), 1);
    chk("R4 idle clear", int'(ifid_clear), 0);

    for (int v = 0; v < 4096; v++) begin
      int s1, s2, dsel, osel, cbit, pa, pf;
      int e_hold, e_take, e_br, e_jmp, e_next, e_word, raw;
      @(posedge clk);
      s1   = (v * 7 + 3) % 32;
      s2   = (v * 13 + 11) % 32;
      dsel = v % 4;
      osel = (v / 4) % 3;
      cbit = (v / 12) % 9;
      pa   = (v * 37 + 5) % 256;
      pf   = (v * 91 + 17) % 256;
      ex_load    = (v / 108) % 2;
      ctl_branch = (v / 216) % 2;
      ctl_jump   = (v / 432) % 2;
      id_instr = {6'((v * 3) % 64), 5'(s1), 5'(s2), 10'((v * 29) % 1024), 6'((v * 11 + v / 64) % 64)};
      case (dsel)
        0: ex_dst = 5'(s1);
        1: ex_dst = 5'(s2);
        2: ex_dst = 5'((s1 + 1) % 32 == s2 ? (s1 + 2) % 32 : (s1 + 1) % 32);
        default: begin ex_dst = 5'(s1); id_instr[20:16] = 5'(s1); s2 = s1; end
      endcase
      opnd_a = 8'(pa);
      case (osel)
        0: opnd_b = 8'(pa);
        1: opnd_b = 8'(pa ^ 128);
        default: opnd_b = 8'(pa ^ 1);
      endcase
      id_pc4 = 8'(pa + 4);
      if_pc4 = 8'(pf);
      raw = (cbit == 8) ? 255 : (1 << cbit);
      {ctl_dst_rd, ctl_aluop, ctl_imm_b, ctl_mem_rd, ctl_mem_wr, ctl_reg_wr, ctl_wb_mem} = 8'(raw);
      @(negedge clk);
      e_hold = (ex_load && (int'(ex_dst) == s1 || int'(ex_dst) == int'(id_instr[20:16]))) ? 1 : 0;
      e_take = (ctl_branch && osel == 0) ? 1 : 0;
      e_jmp  = (int'(id_instr[5:0]) * 4) % 256;
      e_br   = (int'(id_pc4) + e_jmp) % 256;
      e_next = ctl_jump ? e_jmp : (e_take ? e_br : pf);
      e_word = (e_hold || e_take) ? 0 : raw;
      chk("R1 hold_req", int'(hold_req), e_hold);
      chk("R2 pc_load", int'(pc_load), 1 - e_hold);
      chk("R2 ifid_load", int'(ifid_load), 1 - e_hold);
      chk("R3 br_take", int'(br_take), e_take);
      chk("R4 ifid_clear", int'(ifid_clear), (e_take || ctl_jump) ? 1 : 0);
      if (e_hold || e_take) chk("R5 ctl_word bubble", int'(ctl_word), 0);
      else chk("R6 ctl_word packing", int'(ctl_word), e_word);
      chk("R7 br_dest", int'(br_dest), e_br);
      chk("R8 jmp_dest", int'(jmp_dest), e_jmp);
      chk("R9 fetch_next", int'(fetch_next), e_next);
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule